// File: doc/BRIEF.md
# Booth-Recoded Binary64 Multiplier

This block multiplies two IEEE-754 binary64 operands and returns the packed product one clock after the operands are presented. Each operand carries a sign in bit 63, a biased exponent in bits 62 to 52 (bias 1023) and a 52-bit fraction in bits 51 to 0. The hidden leading one is put back in front of each fraction. The two 53-bit significands are then multiplied. The multiplier significand is recoded into radix-4 signed digits, so the multiplicand only ever needs to be taken as 0, ±X or ±2X, and there are 27 partial products instead of 53. A chain of 3:2 carry-save compressors reduces these partial products to a sum word and a carry word. A single carry-propagate adder then turns them into the 106-bit product.

The sign of the result is the XOR of the operand signs. The exponent is the sum of the two biased exponents less one bias. When the integer part of the product is two or more, the significand moves right by one place and the exponent goes up by one. The 52 fraction bits below the leading one are kept, and the bits beneath them are dropped. A 2-bit status code tells the user what kind of exponent the result has, so the logic downstream can handle underflow and overflow itself. Infinity and NaN inputs are not handled, nor are subnormal inputs. Truncation is the only rounding the block does.

Top module: `fp64_booth_mul`

## Requirements
- R1: While rst_n is low, `product` reads 0 and `status` reads 2'b00.
- R2: Bit 63 of `product` equals the XOR of bit 63 of `op_a` and bit 63 of `op_b`.
- R3: For non-zero operands with an in-range result, `product[51:0]` holds the 52 bits just below the leading one of (1.fa × 1.fb), and any lower bits are truncated.
- R4: The unclamped result exponent is Ea + Eb − 1023 + n, where n is 1 when normalisation occurs and 0 otherwise. `product[62:52]` carries this exponent when it lies in the range 0 to 2046.
- R5: When the significand product is 2.0 or more, normalisation occurs: the fraction is taken one place higher and n = 1. Otherwise n = 0.
- R6: `status` is 2'b10 when the result exponent is between 1 and 2046 inclusive.
- R7: `status` is 2'b01 when the result exponent is exactly 0. The exponent field is then 0 and the truncated fraction is kept.
- R8: `status` is 2'b00 when the result exponent is negative, and `product[62:0]` is then 0.
- R9: `status` is 2'b11 when the result exponent is 2047 or more. `product[62:52]` is then all ones and `product[51:0]` is 0.
- R10: An operand is zero when both its exponent field and its fraction field are zero. If either operand is zero, `product[62:0]` is 0, the sign follows R2, and `status` is 2'b01.
- R11: The result of the operands sampled at one rising clock edge appears on `product` and `status` after that edge and stays there for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 64 | Multiplicand, binary64 |
| op_b | input | 64 | Multiplier, binary64 |
| product | output | 64 | Packed binary64 product, registered |
| status | output | 2 | Exponent class: 00 underflow, 01 zero, 10 normal, 11 overflow |

## Verification
The datapath has only one register stage, so any fault in the Booth digit decode, the compressor chain or the final adder shows up on `product` in the cycle after the operands were applied. A wrong digit selection or a dropped carry corrupts the low fraction bits first. The bench uses random fractions so that every group pattern gets exercised. If the normalise decision is wrong, the fraction is offset by one bit and the exponent is off by one. This shows most clearly on operands whose product sits right at 2.0. A fault in the exponent path or the zero detection shows up as a status code in the wrong class and a wrong exponent field. Directed vectors at the boundaries (exponent 0, 2046 and 2047) and random exponents that span underflow through overflow reveal it in that same cycle.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
   typedef enum logic [1:0] {
      EXP_UNDER  = 2'b00,
      EXP_ZERO   = 2'b01,
      EXP_NORMAL = 2'b10,
      EXP_OVER   = 2'b11
   } exp_class_e;
endpackage

// File: rtl/fpm_booth_pp.sv
module fpm_booth_pp #(
   parameter int SIG_W = 53,
   parameter int NUM_PP = (SIG_W + 2) / 2,
   parameter int PROD_W = 2 * SIG_W
) (
   input  logic [SIG_W-1:0]               mcand,
   input  logic [SIG_W-1:0]               mplier,
   output logic [NUM_PP-1:0][PROD_W-1:0]  pp
);
   localparam int EXT_W = 2 * NUM_PP;

   if (EXT_W <= SIG_W) begin : g_bad_ext
      $error("fpm_booth_pp: multiplier extension must leave a zero top bit");
   end

   // Bit 0 stands for the implicit zero below the LSB.
   logic [EXT_W:0] y_ext;
   assign y_ext = {{(EXT_W - SIG_W){1'b0}}, mplier, 1'b0};

   for (genvar g = 0; g < NUM_PP; g++) begin : g_grp
      logic [2:0]        grp;
      logic              sel_one, sel_two, make_neg;
      logic [PROD_W-1:0] mag, val;

      assign grp      = y_ext[2*g+2 -: 3];
      assign sel_one  = grp[0] ^ grp[1];
      assign sel_two  = (grp == 3'b011) || (grp == 3'b100);
      assign make_neg = grp[2] && (grp != 3'b111);

      always_comb begin
         if (sel_two)
            mag = {{(PROD_W - SIG_W - 1){1'b0}}, mcand, 1'b0};
         else if (sel_one)
            mag = {{(PROD_W - SIG_W){1'b0}}, mcand};
         else
            mag = '0;
         val = make_neg ? (~mag + 1'b1) : mag;
      end

      assign pp[g] = val << (2 * g);
   end
endmodule

// File: rtl/fpm_csa_chain.sv
module fpm_csa_chain #(
   parameter int NUM_PP = 27,
   parameter int PROD_W = 106
) (
   input  logic [NUM_PP-1:0][PROD_W-1:0] pp,
   output logic [PROD_W-1:0]             total
);
   if (NUM_PP < 2) begin : g_bad_cnt
      $error("fpm_csa_chain: at least two partial products required");
   end

   logic [NUM_PP-1:0][PROD_W-1:0] s_w;
   logic [NUM_PP-1:0][PROD_W-1:0] c_w;

   assign s_w[0] = pp[0];
   assign c_w[0] = '0;

   for (genvar g = 1; g < NUM_PP; g++) begin : g_stage
      assign s_w[g] = s_w[g-1] ^ c_w[g-1] ^ pp[g];
      assign c_w[g] = ((s_w[g-1] & c_w[g-1]) |
                       (s_w[g-1] & pp[g])    |
                       (c_w[g-1] & pp[g])) << 1;
   end

   // single carry-propagate adder
   assign total = s_w[NUM_PP-1] + c_w[NUM_PP-1];
endmodule

// File: rtl/fpm_norm_pack.sv
module fpm_norm_pack
   import fpm_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   parameter int PROD_W = 2 * (FRAC_W + 1),
   parameter int EW     = EXP_W + 2
) (
   input  logic                        sign_in,
   input  logic                        is_zero,
   input  logic signed [EW-1:0]        exp_sum,
   input  logic [PROD_W-1:0]           prod,
   output logic [EXP_W+FRAC_W:0]       packed_out,
   output exp_class_e                  cls
);
   localparam logic signed [EW-1:0] EXP_TOP = EW'((2 ** EXP_W) - 1);

   logic                 norm;
   logic [FRAC_W-1:0]    frac;
   logic signed [EW-1:0] exp_fin;
   logic                 unused_low;

   assign norm       = prod[PROD_W-1];
   assign frac       = norm ? prod[PROD_W-2 -: FRAC_W] : prod[PROD_W-3 -: FRAC_W];
   assign exp_fin    = exp_sum + $signed({{(EW-1){1'b0}}, norm});
   assign unused_low = ^prod[PROD_W-3-FRAC_W:0];

   always_comb begin
      if (is_zero) begin
         cls        = EXP_ZERO;
         packed_out = {sign_in, {(EXP_W+FRAC_W){1'b0}}};
      end else if (exp_fin < 0) begin
         cls        = EXP_UNDER;
         packed_out = {sign_in, {(EXP_W+FRAC_W){1'b0}}};
      end else if (exp_fin == 0) begin
         cls        = EXP_ZERO;
         packed_out = {sign_in, {EXP_W{1'b0}}, frac};
      end else if (exp_fin < EXP_TOP) begin
         cls        = EXP_NORMAL;
         packed_out = {sign_in, exp_fin[EXP_W-1:0], frac};
      end else begin
         cls        = EXP_OVER;
         packed_out = {sign_in, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end
   end
endmodule

// File: rtl/fp64_booth_mul.sv
module fp64_booth_mul
   import fpm_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [EXP_W+FRAC_W:0]  op_a,
   input  logic [EXP_W+FRAC_W:0]  op_b,
   output logic [EXP_W+FRAC_W:0]  product,
   output logic [1:0]             status
);
   localparam int SIG_W  = FRAC_W + 1;
   localparam int NUM_PP = (SIG_W + 2) / 2;
   localparam int PROD_W = 2 * SIG_W;
   localparam int EW     = EXP_W + 2;
   localparam int BIAS   = (2 ** (EXP_W - 1)) - 1;
   localparam int TOP    = EXP_W + FRAC_W;

   if (EXP_W < 2 || EXP_W > 20) begin : g_bad_exp
      $error("fp64_booth_mul: EXP_W out of supported range");
   end
   if (FRAC_W < 4) begin : g_bad_frac
      $error("fp64_booth_mul: FRAC_W too small");
   end

   logic [EXP_W-1:0]     ea, eb;
   logic [FRAC_W-1:0]    fa, fb;
   logic                 zero_any, sgn;
   logic signed [EW-1:0] exp_sum;
   logic [NUM_PP-1:0][PROD_W-1:0] pp;
   logic [PROD_W-1:0]    prod;
   logic [TOP:0]         packed_w;
   exp_class_e           cls_w;

   assign ea       = op_a[TOP-1 -: EXP_W];
   assign eb       = op_b[TOP-1 -: EXP_W];
   assign fa       = op_a[FRAC_W-1:0];
   assign fb       = op_b[FRAC_W-1:0];
   assign sgn      = op_a[TOP] ^ op_b[TOP];
   assign zero_any = (op_a[TOP-1:0] == '0) || (op_b[TOP-1:0] == '0);
   assign exp_sum  = $signed({2'b00, ea}) + $signed({2'b00, eb}) - EW'(BIAS);

   fpm_booth_pp #(.SIG_W(SIG_W), .NUM_PP(NUM_PP), .PROD_W(PROD_W)) u_pp (
      .mcand  ({1'b1, fa}),
      .mplier ({1'b1, fb}),
      .pp     (pp)
   );

   fpm_csa_chain #(.NUM_PP(NUM_PP), .PROD_W(PROD_W)) u_tree (
      .pp    (pp),
      .total (prod)
   );

   fpm_norm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .PROD_W(PROD_W), .EW(EW)) u_pack (
      .sign_in    (sgn),
      .is_zero    (zero_any),
      .exp_sum    (exp_sum),
      .prod       (prod),
      .packed_out (packed_w),
      .cls        (cls_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         product <= '0;
         status  <= EXP_UNDER;
      end else begin
         product <= packed_w;
         status  <= cls_w;
      end
   end
endmodule

// File: rtl/fp64_booth_mul_chk.sv
module fp64_booth_mul_chk #(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [EXP_W+FRAC_W:0] op_a,
   input logic [EXP_W+FRAC_W:0] op_b,
   input logic [EXP_W+FRAC_W:0] product,
   input logic [1:0]            status
);
   localparam int TOP = EXP_W + FRAC_W;

   logic zero_in;
   assign zero_in = (op_a[TOP-1:0] == '0) || (op_b[TOP-1:0] == '0);

   // R2
   sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> product[TOP] == $past(op_a[TOP] ^ op_b[TOP]));

   // R6
   normal_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status == 2'b10 |-> (product[TOP-1 -: EXP_W] != '0) && (product[TOP-1 -: EXP_W] != '1));

   // R8
   underflow_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status == 2'b00 |-> product[TOP-1:0] == '0);

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status == 2'b11 |-> (product[TOP-1 -: EXP_W] == '1) && (product[FRAC_W-1:0] == '0));

   // R10
   zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(zero_in) |-> (status == 2'b01) && (product[TOP-1:0] == '0));
endmodule

bind fp64_booth_mul fp64_booth_mul_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .op_a    (op_a),
   .op_b    (op_b),
   .product (product),
   .status  (status)
);

// File: tb/fp64_booth_mul_tb.sv
module fp64_booth_mul_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic [63:0] product;
   logic [1:0]  status;

   int vectors = 0;
   int miscompares = 0;

   logic [63:0] exp_r [$];
   logic [1:0]  exp_s [$];
   string       exp_tag [$];

   always #2 clk = ~clk;

   fp64_booth_mul u_dut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .product(product), .status(status)
   );

   task automatic model(input logic [63:0] a, input logic [63:0] b,
                        output logic [63:0] r, output logic [1:0] st, output string tag);
      logic         s;
      logic [105:0] p;
      logic [51:0]  f;
      int           e;
      s = a[63] ^ b[63];
      if (a[62:0] == 0 || b[62:0] == 0) begin
         r = {s, 63'd0}; st = 2'b01; tag = "R10"; return;
      end
      p = {53'd0, 1'b1, a[51:0]} * {53'd0, 1'b1, b[51:0]};
      f = p[105] ? p[104:53] : p[103:52];
      e = int'(a[62:52]) + int'(b[62:52]) - 1023 + (p[105] ? 1 : 0);
      if (e < 0) begin
         r = {s, 63'd0}; st = 2'b00; tag = "R8";
      end else if (e == 0) begin
         r = {s, 11'd0, f}; st = 2'b01; tag = "R7";
      end else if (e <= 2046) begin
         r = {s, e[10:0], f}; st = 2'b10;
         tag = p[105] ? "R2 R3 R4 R5 R6 R11" : "R2 R3 R4 R6 R11";
      end else begin
         r = {s, 11'h7ff, 52'd0}; st = 2'b11; tag = "R9";
      end
   endtask

   task automatic compare_one();
      logic [63:0] r;
      logic [1:0]  st;
      string       t;
      r = exp_r.pop_front(); st = exp_s.pop_front(); t = exp_tag.pop_front();
      vectors++;
      if (product !== r || status !== st) begin
         miscompares++;
         $display("FAIL %s: product=%h status=%b expected product=%h status=%b",
                  t, product, status, r, st);
      end
   endtask

   // called at a negedge: check previous result, then drive new operands
   task automatic apply(input logic [63:0] a, input logic [63:0] b);
      logic [63:0] r;
      logic [1:0]  st;
      string       t;
      if (exp_r.size() != 0) compare_one();
      op_a = a; op_b = b;
      model(a, b, r, st, t);
      exp_r.push_back(r); exp_s.push_back(st); exp_tag.push_back(t);
      @(negedge clk);
   endtask

   function automatic logic [63:0] rnd_op();
      logic [63:0] v;
      v = {$urandom, $urandom};
      if (v[62:52] == 0) v[51:0] = '0;
      return v;
   endfunction

   function automatic logic [63:0] rnd_mid();
      logic [63:0] v;
      v = {$urandom, $urandom};
      v[62:52] = 11'(900 + ($urandom % 250));
      return v;
   endfunction

   initial begin
      #(4 * 200000);
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset values
      vectors++;
      if (product !== 64'd0 || status !== 2'b00) begin
         miscompares++;
         $display("FAIL R1: product=%h status=%b expected product=0 status=00", product, status);
      end
      rst_n = 1'b1;
      @(negedge clk);

      apply(64'h4057400000000000, 64'h3FB1EB851EB851EC); // R3 93 x 0.07
      apply(64'h3FF0000000000000, 64'h3FF0000000000000); // R4 1 x 1
      apply(64'h3FF8000000000000, 64'h3FF8000000000000); // R5 1.5 x 1.5
      apply(64'hC000000000000000, 64'h4008000000000000); // R2 -2 x 3
      apply(64'hBFF0000000000001, 64'hBFFFFFFFFFFFFFFF); // R2 neg x neg
      apply(64'h3FFFFFFFFFFFFFFF, 64'h3FFFFFFFFFFFFFFF); // R3 R5 max fraction
      apply(64'h0010000000000000, 64'h3FE8000000000000); // R7 exponent 0
      apply(64'h0010000000000000, 64'h3FF0000000000000); // R6 exponent 1
      apply(64'h0010000000000000, 64'h0010000000000000); // R8 underflow
      apply(64'h7FE0000000000000, 64'h3FF0000000000000); // R6 exponent 2046
      apply(64'h7FE0000000000000, 64'h4000000000000000); // R9 exponent 2047
      apply(64'h7FEFFFFFFFFFFFFF, 64'h7FEFFFFFFFFFFFFF); // R9 overflow
      apply(64'h0000000000000000, 64'h4057400000000000); // R10 zero a
      apply(64'hC057400000000000, 64'h8000000000000000); // R10 zero b, sign
      apply(64'h0000000000000000, 64'h0000000000000000); // R10 both zero
      for (int i = 0; i < 1500; i++) apply(rnd_mid(), rnd_mid());
      for (int i = 0; i < 1500; i++) apply(rnd_op(), rnd_op());
      compare_one(); // R11 last result

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule